// File: doc/BRIEF.md
# Multi-Channel Temperature Sampling Sequencer

This block sequences a single temperature digitizer that can be steered to one internal sensing point or to one of several external ones. A 32-bit control word, held on a plain input port, selects the source, turns measurement on and off, sets the sampling rate and chooses whether each result is a single sample or the mean of two consecutive samples. The block tells the digitizer model which logical source it is connected to and latches the raw 10-bit two's-complement code it returns at every sampling instant.

Results are published in a 32-bit status word together with a valid flag. When the source changes, the block throws away any half-built average and clears valid. It then waits a fixed settling time before it samples again, so a result taken from the previous source can never appear with valid set. Stopping and restarting on the same source keeps the last result. A soft reset bit in the control word clears the published state.

The sample period and the settling time are parameters counted in clock cycles, so a short simulation can use small values.

Top module: `tsense_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `status_word` is 0 and `conv_src` is 0.
- R2: Sampling takes place only while control bit 0 (start) and bit 2 (enable) are both 1 and bit 1 (soft reset) is 0. With enable at 0, `status_word` does not change, whatever the raw code does.
- R3: The source is selected by control bits 31:30 (mode) and bits 16:13 (index). Mode 2 selects logical source index+1, and an index of NUM_EXT or above selects source NUM_EXT. Any other mode selects logical source 0, the internal sensor. `conv_src` shows the selected logical source from the cycle after the control word is written.
- R4: Control bits 25:24 (rate r) give a sample period of SAMPLE_CYC·2^(3−r) cycles. When a source change is written at clock edge k, a bypass-mode result becomes visible after edge k+SWITCH_CYC+period.
- R5: With control bit 6 at 0, each result is the mean of two consecutive samples, rounded toward minus infinity (-3 and -6 give -5). With bit 6 at 1, each sample is published on its own.
- R6: `status_word` bits 9:0 carry the result as a 10-bit two's-complement value and bit 16 carries valid. All other bits are 0.
- R7: A change of logical source clears valid at that edge and discards a pending half pair. No sample is taken during the following SWITCH_CYC cycles, and valid rises only with data from the new source.
- R8: Writing a control word that decodes to the same logical source leaves valid and the result untouched.
- R9: Clearing start freezes `status_word` and discards a pending half pair. Setting start again on the same source needs no settling: with rate r written at edge k, the first new sample is published after edge k+period−1.
- R10: Soft reset high at an edge clears the result and valid. After it is released, the block settles for SWITCH_CYC cycles, as it does after a source change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Control word (start, soft reset, enable, bypass, rate, mode, index) |
| raw_code | input | CODE_W | Raw two's-complement code from the digitizer for the source on `conv_src` |
| conv_src | output | clog2(NUM_EXT+1) | Logical source the digitizer is connected to (0 = internal) |
| status_word | output | 32 | Result in bits 9:0, valid in bit 16 |

## Verification
The case that matters most is a source change landing on the same edge as a sampling instant, in particular the edge that would complete an averaged pair. The switch must win: the sample is not taken, the half pair is dropped and valid stays low. The bench provokes this by switching source at regular intervals while the raw codes change every cycle, across both averaging settings and two rates, so that switches fall on many different phases of the sample timer. A behavioural model updated at every edge judges the outcome, and any result or valid that differs from it is reported. A soft reset pulse and a stop followed by a restart are checked in the same way against the points in time they predict.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

  localparam int CTRL_W      = 32;
  localparam int CODE_W      = 10;
  localparam int IDX_W       = 4;
  localparam int VALID_POS   = 16;

  localparam int POS_START   = 0;
  localparam int POS_SRST    = 1;
  localparam int POS_ENABLE  = 2;
  localparam int POS_BYPASS  = 6;
  localparam int POS_IDX_LO  = 13;
  localparam int POS_RATE_LO = 24;
  localparam int POS_MODE_LO = 30;

  localparam logic [1:0] MODE_EXTERNAL = 2'd2;

  typedef struct packed {
    logic             start;
    logic             soft_rst;
    logic             enable;
    logic             bypass;
    logic [1:0]       mode;
    logic [1:0]       rate;
    logic [IDX_W-1:0] idx;
  } ctrl_fields_t;

  function automatic ctrl_fields_t split_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_fields_t f;
    f.start    = w[POS_START];
    f.soft_rst = w[POS_SRST];
    f.enable   = w[POS_ENABLE];
    f.bypass   = w[POS_BYPASS];
    f.mode     = w[POS_MODE_LO +: 2];
    f.rate     = w[POS_RATE_LO +: 2];
    f.idx      = w[POS_IDX_LO +: IDX_W];
    return f;
  endfunction

endpackage

// File: rtl/tsense_src_sel.sv
module tsense_src_sel #(
  parameter int NUM_EXT = 4,
  parameter int IDX_W   = 4,
  parameter int SRC_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] idx,
  output logic [SRC_W-1:0] src_q,
  output logic             src_chg
);
  import tsense_pkg::*;

  logic [SRC_W-1:0] src_d;

  always_comb begin
    src_d = '0;
    if (mode == MODE_EXTERNAL) begin
      if (int'(idx) >= NUM_EXT) src_d = SRC_W'(NUM_EXT);
      else                      src_d = SRC_W'(idx) + SRC_W'(1);
    end
  end

  assign src_chg = (src_d != src_q);

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_d;
  end
endmodule

// File: rtl/tsense_pacer.sv
module tsense_pacer #(
  parameter int SAMPLE_CYC = 100000,
  parameter int SWITCH_CYC = 750000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int PER_MAX = SAMPLE_CYC * 8;
  localparam int CNT_MAX = (PER_MAX > SWITCH_CYC) ? PER_MAX : SWITCH_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] settle_cnt;
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] per_load;

  always_comb begin
    per_load = (CNT_W'(SAMPLE_CYC) << (2'd3 - rate)) - CNT_W'(1);
  end

  assign tick = run && !restart && (settle_cnt == '0) && (per_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      settle_cnt <= CNT_W'(SWITCH_CYC);
      per_cnt    <= per_load;
    end else if (!run) begin
      per_cnt    <= per_load;
    end else if (settle_cnt != '0) begin
      settle_cnt <= settle_cnt - CNT_W'(1);
      per_cnt    <= per_load;
    end else if (per_cnt == '0) begin
      per_cnt    <= per_load;
    end else begin
      per_cnt    <= per_cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/tsense_avg.sv
module tsense_avg #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_res,
  input  logic              drop_valid,
  input  logic              drop_pair,
  input  logic              tick,
  input  logic              bypass,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] result,
  output logic              valid
);
  logic              half;
  logic [CODE_W-1:0] first;
  logic [CODE_W:0]   pair_sum;

  assign pair_sum = {first[CODE_W-1], first} + {code[CODE_W-1], code};

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      valid  <= 1'b0;
      half   <= 1'b0;
      first  <= '0;
    end else begin
      if (drop_pair) begin
        half <= 1'b0;
      end else if (tick) begin
        if (bypass) begin
          result <= code;
          valid  <= 1'b1;
          half   <= 1'b0;
        end else if (half) begin
          result <= pair_sum[CODE_W:1];
          valid  <= 1'b1;
          half   <= 1'b0;
        end else begin
          first  <= code;
          half   <= 1'b1;
        end
      end
      if (drop_valid) valid  <= 1'b0;
      if (clear_res)  result <= '0;
    end
  end
endmodule

// File: rtl/tsense_seq.sv
module tsense_seq #(
  parameter int NUM_EXT    = 4,
  parameter int SAMPLE_CYC = 100000,
  parameter int SWITCH_CYC = 750000
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [31:0]                        ctrl_word,
  input  logic [tsense_pkg::CODE_W-1:0]      raw_code,
  output logic [$clog2(NUM_EXT+1)-1:0]       conv_src,
  output logic [31:0]                        status_word
);
  import tsense_pkg::*;

  localparam int SRC_W = $clog2(NUM_EXT + 1);

  ctrl_fields_t      cf;
  logic              run;
  logic              src_chg;
  logic              restart;
  logic              tick;
  logic [CODE_W-1:0] result;
  logic              valid;
  logic              ctrl_unused;

  assign cf          = split_ctrl(ctrl_word);
  assign ctrl_unused = ^{ctrl_word[5:3], ctrl_word[12:7], ctrl_word[23:17], ctrl_word[29:26]};
  assign run         = cf.start && cf.enable && !cf.soft_rst;
  assign restart     = src_chg || cf.soft_rst;

  tsense_src_sel #(
    .NUM_EXT (NUM_EXT),
    .IDX_W   (IDX_W),
    .SRC_W   (SRC_W)
  ) u_src (
    .clk     (clk),
    .rst     (rst),
    .mode    (cf.mode),
    .idx     (cf.idx),
    .src_q   (conv_src),
    .src_chg (src_chg)
  );

  tsense_pacer #(
    .SAMPLE_CYC (SAMPLE_CYC),
    .SWITCH_CYC (SWITCH_CYC)
  ) u_pacer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .run     (run),
    .rate    (cf.rate),
    .tick    (tick)
  );

  tsense_avg #(
    .CODE_W (CODE_W)
  ) u_avg (
    .clk        (clk),
    .rst        (rst),
    .clear_res  (cf.soft_rst),
    .drop_valid (restart),
    .drop_pair  (restart || !run),
    .tick       (tick),
    .bypass     (cf.bypass),
    .code       (raw_code),
    .result     (result),
    .valid      (valid)
  );

  always_comb begin
    status_word                     = '0;
    status_word[CODE_W-1:0]         = result;
    status_word[VALID_POS]          = valid;
  end
endmodule

// File: rtl/tsense_seq_chk.sv
module tsense_seq_chk #(
  parameter int NUM_EXT    = 4,
  parameter int SAMPLE_CYC = 100000,
  parameter int SWITCH_CYC = 750000
) (
  input logic                         clk,
  input logic                         rst,
  input logic [31:0]                  ctrl_word,
  input logic [$clog2(NUM_EXT+1)-1:0] conv_src,
  input logic [31:0]                  status_word
);
  localparam int SRC_W = $clog2(NUM_EXT + 1);
  localparam logic [31:0] MIN_GAP = 32'(SWITCH_CYC + SAMPLE_CYC);

  logic [SRC_W-1:0] prev_src;
  logic [31:0]      since_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_src  <= '0;
      since_chg <= '0;
    end else begin
      prev_src <= conv_src;
      if (conv_src != prev_src)      since_chg <= 32'd1;
      else if (since_chg != '1)      since_chg <= since_chg + 32'd1;
    end
  end

  assert_switch_drops_valid_R7: assert property (@(posedge clk) disable iff (rst)
    (conv_src != $past(conv_src)) |-> !status_word[16]);

  assert_settle_window_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(status_word[16]) |-> (since_chg >= MIN_GAP));

  assert_rise_needs_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(status_word[16]) |-> $past(ctrl_word[0] && ctrl_word[2] && !ctrl_word[1]));

  assert_stopped_holds_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!ctrl_word[0] && !ctrl_word[1]) && !$past(rst) && (conv_src == $past(conv_src)))
      |-> $stable(status_word));

  assert_softreset_clears_R10: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_word[1]) |-> (status_word == 32'd0));

  assert_src_range_R3: assert property (@(posedge clk) disable iff (rst)
    int'(conv_src) <= NUM_EXT);
endmodule

bind tsense_seq tsense_seq_chk #(
  .NUM_EXT    (NUM_EXT),
  .SAMPLE_CYC (SAMPLE_CYC),
  .SWITCH_CYC (SWITCH_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctrl_word   (ctrl_word),
  .conv_src    (conv_src),
  .status_word (status_word)
);

// File: tb/test_tsense_seq.sv
module test_tsense_seq;
  localparam int SC = 4;
  localparam int SW = 20;
  localparam int NE = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [31:0]       ctrl = 32'd0;
  logic [9:0]        raw;
  logic [2:0]        conv_src;
  logic [31:0]       status;
  logic signed [9:0] sens [0:4];

  int    checks = 0;
  int    errors = 0;
  bit    cmp_on = 1'b0;
  bit    done   = 1'b0;
  string phase  = "R1";

  int m_src, m_settle, m_per, m_half, m_first, m_res, m_valid, m_code, m_d;

  always #10 clk = ~clk;

  assign raw = sens[conv_src];

  tsense_seq #(.NUM_EXT(NE), .SAMPLE_CYC(SC), .SWITCH_CYC(SW)) i_tsense_seq (
    .clk(clk), .rst(rst), .ctrl_word(ctrl), .raw_code(raw),
    .conv_src(conv_src), .status_word(status));

  function automatic logic [31:0] mk(input bit st, input bit rb, input bit en, input bit byp,
                                     input int mode, input int idx, input int osr);
    logic [31:0] w = 32'd0;
    w[0] = st; w[1] = rb; w[2] = en; w[6] = byp;
    w[31:30] = 2'(mode); w[16:13] = 4'(idx); w[25:24] = 2'(osr);
    return w;
  endfunction

  function automatic int decode(input logic [31:0] c);
    if (c[31:30] == 2'd2) return (int'(c[16:13]) >= NE) ? NE : int'(c[16:13]) + 1;
    return 0;
  endfunction

  function automatic int period(input logic [1:0] o);
    return SC << (3 - int'(o));
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_src = 0; m_settle = SW; m_per = period(ctrl[25:24]) - 1;
      m_half = 0; m_first = 0; m_res = 0; m_valid = 0;
    end else begin
      m_d = decode(ctrl);
      if (m_d != m_src || ctrl[1]) begin
        m_src = m_d; m_settle = SW; m_per = period(ctrl[25:24]) - 1;
        m_half = 0; m_valid = 0;
        if (ctrl[1]) m_res = 0;
      end else if (!(ctrl[0] && ctrl[2])) begin
        m_per = period(ctrl[25:24]) - 1; m_half = 0;
      end else if (m_settle > 0) begin
        m_settle = m_settle - 1; m_per = period(ctrl[25:24]) - 1;
      end else if (m_per == 0) begin
        m_per = period(ctrl[25:24]) - 1;
        m_code = int'(sens[m_src]);
        if (ctrl[6]) begin m_res = m_code; m_valid = 1; m_half = 0; end
        else if (m_half != 0) begin m_res = (m_first + m_code) >>> 1; m_valid = 1; m_half = 0; end
        else begin m_first = m_code; m_half = 1; end
      end else begin
        m_per = m_per - 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic [31:0] e;
      logic [9:0]  r10;
      r10 = m_res[9:0];
      e = {15'd0, m_valid[0], 6'd0, r10};
      chk(phase, "model status", status, e);
      chk(phase, "model source", {29'd0, conv_src}, 32'(m_src));
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int n;
    for (int c = 0; c <= NE; c++) sens[c] = '0;
    ticks(3);
    cmp_on = 1'b1;
    chk("R1", "status in reset", status, 32'd0);
    chk("R1", "source in reset", {29'd0, conv_src}, 32'd0);
    rst = 1'b0;
    ticks(1);
    chk("R1", "status after reset", status, 32'd0);

    phase = "R4";
    sens[3] = 10'sd100;
    ctrl = mk(1, 0, 1, 1, 2, 2, 3);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) begin
        chk("R3", "external index 2", {29'd0, conv_src}, 32'd3);
        chk("R7", "valid low after switch", {31'd0, status[16]}, 32'd0);
      end
    end while (!status[16] && n < 500);
    chk("R4", "bypass latency", 32'(n), 32'(SW + SC + 1));
    chk("R6", "status layout", status, 32'h0001_0064);

    phase = "R5";
    sens[1] = -10'sd3;
    ctrl = mk(1, 0, 1, 0, 2, 0, 3);
    ticks(SW + SC + 1);
    chk("R5", "pair pending", {31'd0, status[16]}, 32'd0);
    sens[1] = -10'sd6;
    ticks(SC);
    chk("R5", "floor mean", status, 32'h0001_03FB);

    phase = "R8";
    sens[0] = 10'sd33;
    ctrl = mk(1, 0, 1, 1, 0, 0, 3);
    ticks(SW + SC + 1);
    chk("R8", "internal result", status, 32'h0001_0021);
    ctrl = mk(1, 0, 1, 1, 3, 5, 3);
    ticks(1);
    chk("R3", "mode 3 is internal", {29'd0, conv_src}, 32'd0);
    chk("R8", "valid kept", {31'd0, status[16]}, 32'd1);
    ticks(SC * 3);
    chk("R8", "valid still kept", {31'd0, status[16]}, 32'd1);

    phase = "R3";
    sens[4] = -10'sd200;
    ctrl = mk(1, 0, 1, 1, 2, 9, 3);
    ticks(1);
    chk("R3", "index clamp", {29'd0, conv_src}, 32'd4);
    ticks(SW + SC);
    chk("R6", "negative code", status, 32'h0001_0338);

    phase = "R9";
    ctrl = mk(0, 0, 1, 1, 2, 9, 3);
    sens[4] = 10'sd50;
    ticks(40);
    chk("R9", "stopped frozen", status, 32'h0001_0338);
    ctrl = mk(1, 0, 1, 1, 2, 9, 3);
    ticks(SC - 1);
    chk("R9", "before first restart sample", status, 32'h0001_0338);
    ticks(1);
    chk("R9", "first restart sample", status, 32'h0001_0032);

    phase = "R2";
    ctrl = mk(1, 0, 0, 1, 2, 9, 3);
    sens[4] = 10'sd77;
    ticks(30);
    chk("R2", "enable low frozen", status, 32'h0001_0032);

    phase = "R10";
    ctrl = mk(1, 1, 1, 1, 2, 9, 3);
    ticks(1);
    chk("R10", "soft reset clears", status, 32'd0);
    ctrl = mk(1, 0, 1, 1, 2, 9, 3);
    ticks(SW + SC - 1);
    chk("R10", "settling after soft reset", {31'd0, status[16]}, 32'd0);
    ticks(1);
    chk("R10", "first result after soft reset", status, 32'h0001_004D);

    phase = "R4";
    sens[2] = -10'sd1;
    ctrl = mk(1, 0, 1, 1, 2, 1, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!status[16] && n < 500);
    chk("R4", "rate 1 latency", 32'(n), 32'(SW + 4 * SC + 1));
    chk("R4", "rate 1 result", status, 32'h0001_03FF);

    phase = "R7";
    for (int it = 0; it < 14; it++) begin
      int ch;
      ch = (it * 3) % (NE + 1);
      if (ch == 0) ctrl = mk(1, 0, 1, it % 2, 0, 0, 3 - (it % 2));
      else         ctrl = mk(1, 0, 1, it % 2, 2, ch - 1, 3 - (it % 2));
      for (int j = 0; j < 47 + (it % 5); j++) begin
        for (int c = 0; c <= NE; c++) sens[c] = 10'(((it * 37 + j * 11 + c * 5) % 200) - 100);
        @(negedge clk);
      end
    end

    ticks(2);
    finish_run();
  end
endmodule